// File: doc/BRIEF.md
# Reset Cause Capture Register

This block keeps a small status word that tells software why the chip last left reset. Each reset source raises a single-cycle pulse toward the block, and the matching flag in a 6-bit cause word is set and held. Software reads the word once. That read empties it, so a later read shows only causes that arrived after it.

The reset sequencer strobes `stage_init_i` when it runs its settings-initialisation stage. That strobe normally wipes the cause word. A stage entered because a watchdog expired must leave the word intact. To allow this, a watchdog pulse arms a guard, and the next strobe consumes the guard instead of clearing. A software reset or a reset-pin reset never passes through that stage, so those sources only add their own flag.

A hardware watchdog expiry shows up in the cause word only as the shared init flag, the same flag the init pin raises. To tell the two apart, the block keeps a separate CPU-fail flag. Only the hardware watchdog sets it. Only an explicit software clear removes it. No read, strobe or later reset source touches it.

Top module: `rst_cause_reg`

## Requirements
- R1: A pulse on a cause input sets its flag in `cause_o` at the next clock edge. The bit positions are: bit 0 init pin or hardware watchdog, bit 1 standby pin, bit 2 software watchdog, bit 3 reset pin, bit 4 software reset, bit 5 low-voltage reset.
- R2: A `hw_wdt_i` pulse sets `cause_o` bit 0 and `cpu_fail_o`, and no other cause bit.
- R3: Flags are sticky. A set flag stays set until a read or a clearing stage strobe. Causes arriving in different cycles accumulate.
- R4: A cycle with `rd_i` high and no cause pulse leaves `cause_o` all zero from the next edge onward.
- R5: When a cause pulse arrives in the same cycle as a clearing read or a clearing stage strobe, that new flag is kept and all earlier flags are cleared.
- R6: `stage_init_i` clears `cause_o` when no watchdog pulse (hardware or software) has arrived since the previous strobe and none arrives in the same cycle.
- R7: When a watchdog pulse arrived since the previous strobe, or arrives in the same cycle, `stage_init_i` leaves the existing flags unchanged. The strobe consumes that watchdog mark, so the following strobe clears again. A read does not consume the mark.
- R8: Software-reset and reset-pin pulses only add their own flag and never clear other flags.
- R9: `cpu_fail_o` stays set until a `cpuf_clr_i` strobe. Reads, stage strobes and other cause pulses do not affect it. A hardware watchdog pulse in the same cycle as the clear wins.
- R10: While `rst_ni` is low, `cause_o` and `cpu_fail_o` are zero. The reset takes effect at once and is released on a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_pin_i | input | 1 | Init-pin reset pulse |
| hw_wdt_i | input | 1 | Hardware watchdog expiry pulse |
| standby_i | input | 1 | Standby-pin reset pulse |
| sw_wdt_i | input | 1 | Software watchdog expiry pulse |
| ext_rst_i | input | 1 | Reset-pin pulse |
| sw_rst_i | input | 1 | Software reset pulse |
| lowv_i | input | 1 | Low-voltage reset pulse |
| stage_init_i | input | 1 | Settings-initialisation stage strobe from the sequencer |
| rd_i | input | 1 | Read strobe for the cause word (clears it) |
| cpuf_clr_i | input | 1 | Software clear strobe for the CPU-fail flag |
| cause_o | output | 6 | Sticky cause word |
| cpu_fail_o | output | 1 | Hardware-watchdog CPU-fail flag |

## Verification
Some properties need only the ports from one cycle to the next, and the assertions check those on every cycle. They cover the per-source setting of flags, stickiness without a read or strobe, emptying on a read, a strobe that carries its own watchdog pulse preserving the flags, the holding and clearing of the CPU-fail flag, and the reset state.

Other behaviours depend on history and only the bench scenarios show them. One is whether a watchdog pulse several cycles back arms the next strobe. Another is that the strobe consumes the mark so the second strobe clears. The bench also covers ordering when a new cause meets a clear in the same cycle, a simultaneous pulse from every source, and an asynchronous reset taken mid-run.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int unsigned NUM_CAUSES = 6;

  // Bit positions inside the cause word.
  localparam int unsigned IDX_INIT  = 0;  // init pin or hardware watchdog
  localparam int unsigned IDX_STBY  = 1;  // standby pin
  localparam int unsigned IDX_SWDT  = 2;  // software watchdog
  localparam int unsigned IDX_EXT   = 3;  // reset pin
  localparam int unsigned IDX_SWRST = 4;  // software reset
  localparam int unsigned IDX_LOWV  = 5;  // low-voltage reset

  typedef logic [NUM_CAUSES-1:0] cause_vec_t;
endpackage

// File: rtl/rcr_rst_sync.sv
module rcr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/rcr_sticky_bit.sv
// Single flag: set wins over clear, holds otherwise.
module rcr_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic en;
  logic d;

  always_comb begin
    en = set_i | clr_i;
    d  = set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_o <= 1'b0;
    else if (en)  q_o <= d;
  end
endmodule

// File: rtl/rcr_cause_enc.sv
// Maps the individual source pulses onto cause-word set bits.
module rcr_cause_enc
  import rcr_pkg::*;
(
  input  logic       init_pin_i,
  input  logic       hw_wdt_i,
  input  logic       standby_i,
  input  logic       sw_wdt_i,
  input  logic       ext_rst_i,
  input  logic       sw_rst_i,
  input  logic       lowv_i,
  output cause_vec_t set_o,
  output logic       wdt_evt_o
);
  always_comb begin
    set_o            = '0;
    set_o[IDX_INIT]  = init_pin_i | hw_wdt_i;
    set_o[IDX_STBY]  = standby_i;
    set_o[IDX_SWDT]  = sw_wdt_i;
    set_o[IDX_EXT]   = ext_rst_i;
    set_o[IDX_SWRST] = sw_rst_i;
    set_o[IDX_LOWV]  = lowv_i;
    wdt_evt_o        = hw_wdt_i | sw_wdt_i;
  end
endmodule

// File: rtl/rcr_init_guard.sv
// Remembers a watchdog pulse so the next stage strobe spares the cause word.
module rcr_init_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdt_evt_i,
  input  logic stage_init_i,
  output logic init_clr_o
);
  logic armed_q;
  logic arm_set;
  logic keep;

  always_comb begin
    arm_set    = wdt_evt_i & ~stage_init_i;
    keep       = armed_q | wdt_evt_i;
    init_clr_o = stage_init_i & ~keep;
  end

  rcr_sticky_bit armed_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (arm_set),
    .clr_i  (stage_init_i),
    .q_o    (armed_q)
  );
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  init_pin_i,
  input  logic                  hw_wdt_i,
  input  logic                  standby_i,
  input  logic                  sw_wdt_i,
  input  logic                  ext_rst_i,
  input  logic                  sw_rst_i,
  input  logic                  lowv_i,
  input  logic                  stage_init_i,
  input  logic                  rd_i,
  input  logic                  cpuf_clr_i,
  output logic [NUM_CAUSES-1:0] cause_o,
  output logic                  cpu_fail_o
);
  logic       rst_sync_n;
  cause_vec_t set_vec;
  logic       wdt_evt;
  logic       init_clr;
  logic       word_clr;
  cause_vec_t flags_q;

  rcr_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  rcr_cause_enc enc_i (
    .init_pin_i (init_pin_i),
    .hw_wdt_i   (hw_wdt_i),
    .standby_i  (standby_i),
    .sw_wdt_i   (sw_wdt_i),
    .ext_rst_i  (ext_rst_i),
    .sw_rst_i   (sw_rst_i),
    .lowv_i     (lowv_i),
    .set_o      (set_vec),
    .wdt_evt_o  (wdt_evt)
  );

  rcr_init_guard guard_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .wdt_evt_i    (wdt_evt),
    .stage_init_i (stage_init_i),
    .init_clr_o   (init_clr)
  );

  always_comb begin
    word_clr = rd_i | init_clr;
  end

  for (genvar b = 0; b < NUM_CAUSES; b++) begin : g_flag
    rcr_sticky_bit flag_i (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .set_i  (set_vec[b]),
      .clr_i  (word_clr),
      .q_o    (flags_q[b])
    );
  end

  rcr_sticky_bit cpuf_i (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .set_i  (hw_wdt_i),
    .clr_i  (cpuf_clr_i),
    .q_o    (cpu_fail_o)
  );

  assign cause_o = flags_q;
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk
  import rcr_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  init_pin_i,
  input logic                  hw_wdt_i,
  input logic                  standby_i,
  input logic                  sw_wdt_i,
  input logic                  ext_rst_i,
  input logic                  sw_rst_i,
  input logic                  lowv_i,
  input logic                  stage_init_i,
  input logic                  rd_i,
  input logic                  cpuf_clr_i,
  input logic [NUM_CAUSES-1:0] cause_o,
  input logic                  cpu_fail_o
);
  logic any_pulse;
  assign any_pulse = init_pin_i | hw_wdt_i | standby_i | sw_wdt_i |
                     ext_rst_i | sw_rst_i | lowv_i;

  assert_flag_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowv_i |=> cause_o[IDX_LOWV]);

  assert_hw_wdt_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_wdt_i |=> (cause_o[IDX_INIT] && cpu_fail_o));

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !stage_init_i) |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

  assert_read_empties_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !any_pulse) |=> (cause_o == '0));

  assert_new_cause_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sw_rst_i) |=> cause_o[IDX_SWRST]);

  assert_wdt_strobe_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_init_i && !rd_i && (hw_wdt_i || sw_wdt_i))
      |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

  assert_cpuf_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_fail_o && !cpuf_clr_i) |=> cpu_fail_o);

  assert_cpuf_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpuf_clr_i && !hw_wdt_i) |=> !cpu_fail_o);

  assert_reset_state_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (cause_o == '0 && !cpu_fail_o));
endmodule

bind rst_cause_reg rst_cause_reg_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_sync_n),
  .init_pin_i   (init_pin_i),
  .hw_wdt_i     (hw_wdt_i),
  .standby_i    (standby_i),
  .sw_wdt_i     (sw_wdt_i),
  .ext_rst_i    (ext_rst_i),
  .sw_rst_i     (sw_rst_i),
  .lowv_i       (lowv_i),
  .stage_init_i (stage_init_i),
  .rd_i         (rd_i),
  .cpuf_clr_i   (cpuf_clr_i),
  .cause_o      (cause_o),
  .cpu_fail_o   (cpu_fail_o)
);

// File: tb/rst_cause_reg_tb_top.sv
`timescale 1ns/1ps
module rst_cause_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] pulses = '0;  // b0 init pin, b1 hw wdt, b2 standby, b3 sw wdt, b4 ext, b5 sw rst, b6 lowv
  logic stage = 1'b0;
  logic rd = 1'b0;
  logic clr = 1'b0;
  logic [5:0] cause;
  logic cpuf;
  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rst_cause_reg dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .init_pin_i   (pulses[0]),
    .hw_wdt_i     (pulses[1]),
    .standby_i    (pulses[2]),
    .sw_wdt_i     (pulses[3]),
    .ext_rst_i    (pulses[4]),
    .sw_rst_i     (pulses[5]),
    .lowv_i       (pulses[6]),
    .stage_init_i (stage),
    .rd_i         (rd),
    .cpuf_clr_i   (clr),
    .cause_o      (cause),
    .cpu_fail_o   (cpuf)
  );

  // {req number, pulses, stage, rd, cpuf clear, expected cause, expected cpu fail}
  localparam int NV = 28;
  localparam logic [20:0] VECS [NV] = '{
    {4'd1,  7'b0000001, 1'b0, 1'b0, 1'b0, 6'h01, 1'b0},  // R1 init pin
    {4'd3,  7'b0000100, 1'b0, 1'b0, 1'b0, 6'h03, 1'b0},  // R3 accumulate standby
    {4'd1,  7'b0001000, 1'b0, 1'b0, 1'b0, 6'h07, 1'b0},  // R1 sw wdt, arms guard
    {4'd7,  7'b0000000, 1'b1, 1'b0, 1'b0, 6'h07, 1'b0},  // R7 armed strobe keeps
    {4'd6,  7'b0000000, 1'b1, 1'b0, 1'b0, 6'h00, 1'b0},  // R6 mark consumed, clears
    {4'd8,  7'b0010000, 1'b0, 1'b0, 1'b0, 6'h08, 1'b0},  // R8 reset pin
    {4'd8,  7'b0100000, 1'b0, 1'b0, 1'b0, 6'h18, 1'b0},  // R8 sw reset keeps others
    {4'd1,  7'b1000000, 1'b0, 1'b0, 1'b0, 6'h38, 1'b0},  // R1 low voltage
    {4'd4,  7'b0000000, 1'b0, 1'b1, 1'b0, 6'h00, 1'b0},  // R4 read empties
    {4'd4,  7'b0000000, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0},  // R4 stays empty
    {4'd2,  7'b0000010, 1'b0, 1'b0, 1'b0, 6'h01, 1'b1},  // R2 hw wdt
    {4'd9,  7'b0000000, 1'b0, 1'b1, 1'b0, 6'h00, 1'b1},  // R9 read leaves cpu fail
    {4'd9,  7'b0000000, 1'b1, 1'b0, 1'b0, 6'h00, 1'b1},  // R9 strobe leaves cpu fail
    {4'd8,  7'b0010000, 1'b0, 1'b0, 1'b0, 6'h08, 1'b1},  // R8
    {4'd5,  7'b0100000, 1'b0, 1'b1, 1'b0, 6'h10, 1'b1},  // R5 read + sw reset
    {4'd5,  7'b0000001, 1'b1, 1'b0, 1'b0, 6'h01, 1'b1},  // R5 clearing strobe + init pin
    {4'd9,  7'b0000010, 1'b0, 1'b0, 1'b1, 6'h01, 1'b1},  // R9 set wins over clear
    {4'd9,  7'b0000000, 1'b0, 1'b0, 1'b1, 6'h01, 1'b0},  // R9 clear
    {4'd7,  7'b0000000, 1'b1, 1'b0, 1'b0, 6'h01, 1'b0},  // R7 hw wdt mark keeps
    {4'd3,  7'b0010000, 1'b0, 1'b0, 1'b0, 6'h09, 1'b0},  // R3
    {4'd7,  7'b0001000, 1'b1, 1'b0, 1'b0, 6'h0D, 1'b0},  // R7 same-cycle wdt keeps
    {4'd6,  7'b0000000, 1'b1, 1'b0, 1'b0, 6'h00, 1'b0},  // R6 same-cycle mark consumed
    {4'd1,  7'b1111111, 1'b0, 1'b0, 1'b0, 6'h3F, 1'b1},  // R1 every source
    {4'd7,  7'b0000000, 1'b0, 1'b1, 1'b0, 6'h00, 1'b1},  // R7 read keeps the mark
    {4'd9,  7'b0000000, 1'b0, 1'b0, 1'b1, 6'h00, 1'b0},  // R9
    {4'd8,  7'b0010000, 1'b0, 1'b0, 1'b0, 6'h08, 1'b0},  // R8
    {4'd7,  7'b0000000, 1'b1, 1'b0, 1'b0, 6'h08, 1'b0},  // R7 mark from every-source cycle
    {4'd6,  7'b0000000, 1'b1, 1'b0, 1'b0, 6'h00, 1'b0}   // R6
  };

  task automatic check(input string tag, input logic [5:0] exp_c, input logic exp_f);
    n_checks++;
    if (cause !== exp_c || cpuf !== exp_f) begin
      n_fail++;
      $display("FAIL %s: cause=%h cpu_fail=%b expected cause=%h cpu_fail=%b",
               tag, cause, cpuf, exp_c, exp_f);
    end
  endtask

  // Drive for one cycle starting at a falling edge; check at the next falling edge.
  task automatic apply(input logic [6:0] p, input logic s, input logic r, input logic c);
    pulses = p; stage = s; rd = r; clr = c;
    @(negedge clk);
    pulses = '0; stage = 1'b0; rd = 1'b0; clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 in reset", 6'h00, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 after release", 6'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VECS[i];
      apply(v[16:10], v[9], v[8], v[7]);
      check($sformatf("R%0d vector %0d", v[20:17], i), v[6:1], v[0]);
    end

    // R9: cpu fail survives many reads and strobes
    apply(7'b0000010, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) apply(7'b0000000, 1'b1, 1'b1, 1'b0);
    check("R9 cpu fail after reads and strobes", 6'h00, 1'b1);

    // R5: new standby cause during a read
    apply(7'b0010000, 1'b0, 1'b0, 1'b0);
    apply(7'b0000100, 1'b0, 1'b1, 1'b0);
    check("R5 standby during read", 6'h02, 1'b1);

    // R10: asynchronous reset mid-run clears at once
    apply(7'b1000000, 1'b0, 1'b0, 1'b0);
    #1 rst_n = 1'b0;
    #0.5 check("R10 async reset", 6'h00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    apply(7'b0000100, 1'b0, 1'b0, 1'b0);
    check("R1 standby after reset", 6'h02, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule